// File: doc/BRIEF.md
# Byte-Buffered Serial Port

This block is a register-mapped asynchronous serial port. It holds exactly one byte in each direction. Frames are fixed at eight data bits, least significant bit first, with no parity and one stop bit. The bit period is a whole number of system clocks, set by a programmable divisor. A host reaches five 32-bit registers over a simple word-addressed bus: data, state, control, interrupt flags and divisor. Reads have no wait states.

The transmitter moves the held byte into its shifter while transmission is enabled. The line then carries a low start bit, the data bits and a high stop bit. The line idles high. The receiver synchronises the serial input and waits for a falling edge. It confirms the start bit at the middle of its period and then samples each later bit at its midpoint. A frame whose stop bit is low is dropped. A byte that arrives while the receive buffer is still full is lost and raises an overrun. A write to the data register while the transmit buffer is full also raises an overrun.

The block has three interrupt lines: receive, transmit, and a shared overrun line. Each line is an event flag gated by an enable bit. Software clears a flag by writing 1 to it.

Top module: `byte_uart`

## Requirements
- R1: After reset, every register reads zero except the divisor, which reads 16. serial_tx is high and all three interrupt outputs are low.
- R2: Word addresses select the registers: 0 data, 1 state, 2 control, 3 interrupt flags, 4 divisor. Any other address reads zero. State bits are 0 TX full, 1 RX full, 2 TX overrun and 3 RX overrun. Control bits are 0 TX enable, 1 RX enable, 2 TX interrupt enable, 3 RX interrupt enable, 4 TX-overrun interrupt enable and 5 RX-overrun interrupt enable. Flag bits are 0 TX, 1 RX, 2 TX overrun and 3 RX overrun.
- R3: A transmitted frame is a low start bit, data bits 0 to 7 and a high stop bit. Each bit lasts exactly divisor clocks. A byte that is waiting when the stop bit ends starts its frame on the next clock with no idle gap.
- R4: A write to data while TX is not full stores the byte and sets state bit 0. A write while TX is full leaves the held byte unchanged and sets state bit 2 and flag bit 2.
- R5: A valid frame loads the receive buffer and sets state bit 1 and flag bit 1. Reading data returns the byte and clears state bit 1.
- R6: A frame that completes while RX is full sets state bit 3 and flag bit 3 and keeps the earlier byte.
- R7: Writing 1 to a bit of the flag register clears that flag. Writing 0 leaves it unchanged.
- R8: Writing 1 to state bit 2 or state bit 3 clears that sticky overrun bit. Writing to state bits 0 and 1 has no effect.
- R9: irq_tx is flag 0 AND control 2. irq_rx is flag 1 AND control 3. irq_ovr is (flag 2 AND control 4) OR (flag 3 AND control 5).
- R10: The divisor holds 21 bits. A written value below 16 is stored as 16, and bits above bit 20 are dropped.
- R11: Flag 0 is set when the held byte moves into the shifter. While control bit 0 is clear, the held byte waits, state bit 0 stays set and the line stays high.
- R12: The receiver drops a start pulse that is high again at its midpoint and a frame whose stop bit is low. It ignores all line activity while control bit 1 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| serial_rx | input | 1 | Serial receive line |
| serial_tx | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_ovr | output | 1 | Combined overrun interrupt |

## Verification
The bench checks every transmitted bit at both its first and its last clock, across several divisors and data patterns. A shifter with an off-by-one bit length, the wrong bit order or a one-clock gap between back-to-back frames fails at a bit edge. The receiver is driven with good frames, a frame with a low stop bit, a short start glitch and traffic sent while receive is disabled. A design that loads a bad frame or skips the midpoint start check leaves state bit 1 set where zero is expected. Overrun cases look for the byte the design kept, so a design that replaces the buffered byte on overrun returns the wrong data. The bench also checks that writing 0 leaves flags unchanged, and that a divisor below 16 is clamped while a full-width value is kept.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;
    localparam int DIV_W      = 21;
    localparam int MIN_DIV    = 16;
    localparam int FRAME_BITS = 10;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 3;

    localparam logic [ADDR_W-1:0] W_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] W_STATE = 3'd1;
    localparam logic [ADDR_W-1:0] W_CTRL  = 3'd2;
    localparam logic [ADDR_W-1:0] W_FLAG  = 3'd3;
    localparam logic [ADDR_W-1:0] W_DIV   = 3'd4;

    localparam int C_TX_EN    = 0;
    localparam int C_RX_EN    = 1;
    localparam int C_TX_IE    = 2;
    localparam int C_RX_IE    = 3;
    localparam int C_TXOVR_IE = 4;
    localparam int C_RXOVR_IE = 5;

    localparam int F_TX    = 0;
    localparam int F_RX    = 1;
    localparam int F_TXOVR = 2;
    localparam int F_RXOVR = 3;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_phase_e;
endpackage

// File: rtl/byte_uart_tx.sv
module byte_uart_tx
    import byte_uart_pkg::*;
#(
    parameter int TX_DIV_W = DIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TX_DIV_W-1:0] div,
    input  logic                load,
    input  logic [7:0]          load_byte,
    output logic                ready,
    output logic                txd
);
    localparam logic [3:0] LAST_IDX = 4'(FRAME_BITS - 1);

    typedef struct packed {
        logic                busy;
        logic [3:0]          idx;
        logic [TX_DIV_W-1:0] cnt;
        logic [8:0]          sh;
        logic                txd;
    } tx_s;

    tx_s s_d, s_q;
    logic tick, last;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt >= div - 1'b1);
        last = s_q.busy && tick && (s_q.idx == LAST_IDX);
        if (load) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
            s_d.cnt  = '0;
            s_d.txd  = 1'b0;
            s_d.sh   = {1'b1, load_byte};
        end else if (s_q.busy) begin
            if (tick) begin
                s_d.cnt = '0;
                if (s_q.idx == LAST_IDX) begin
                    s_d.busy = 1'b0;
                    s_d.txd  = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 4'd1;
                    s_d.txd = s_q.sh[0];
                    s_d.sh  = {1'b1, s_q.sh[8:1]};
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{busy: 1'b0, idx: '0, cnt: '0, sh: '1, txd: 1'b1};
        else        s_q <= s_d;
    end

    assign ready = !s_q.busy || last;
    assign txd   = s_q.txd;
endmodule

// File: rtl/byte_uart_rx.sv
module byte_uart_rx
    import byte_uart_pkg::*;
#(
    parameter int RX_DIV_W = DIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [RX_DIV_W-1:0] div,
    input  logic                rxd,
    output logic                valid,
    output logic [7:0]          rx_byte
);
    typedef struct packed {
        logic [2:0]          sync;
        rx_phase_e           phase;
        logic [RX_DIV_W-1:0] cnt;
        logic [2:0]          idx;
        logic [7:0]          sh;
        logic                valid;
    } rx_s;

    rx_s s_d, s_q;
    logic                line, fall, full_tick, half_tick;
    logic [RX_DIV_W-1:0] half;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.sync  = {s_q.sync[1:0], rxd};
        line      = s_q.sync[1];
        fall      = s_q.sync[2] && !line;
        half      = {1'b0, div[RX_DIV_W-1:1]};
        half_tick = (s_q.cnt >= half - 1'b1);
        full_tick = (s_q.cnt >= div - 1'b1);
        if (!en) begin
            s_d.phase = RX_IDLE;
        end else begin
            unique case (s_q.phase)
                RX_IDLE: begin
                    if (fall) begin
                        s_d.phase = RX_START;
                        s_d.cnt   = '0;
                    end
                end
                RX_START: begin
                    if (half_tick) begin
                        s_d.cnt   = '0;
                        s_d.idx   = '0;
                        s_d.phase = line ? RX_IDLE : RX_DATA;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (full_tick) begin
                        s_d.cnt = '0;
                        s_d.sh  = {line, s_q.sh[7:1]};
                        s_d.idx = s_q.idx + 3'd1;
                        if (s_q.idx == 3'd7) s_d.phase = RX_STOP;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (full_tick) begin
                        s_d.cnt   = '0;
                        s_d.phase = RX_IDLE;
                        s_d.valid = line;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.phase = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sync: '1, phase: RX_IDLE, cnt: '0, idx: '0, sh: '0, valid: 1'b0};
        else        s_q <= s_d;
    end

    assign valid   = s_q.valid;
    assign rx_byte = s_q.sh;
endmodule

// File: rtl/byte_uart.sv
module byte_uart
    import byte_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              serial_rx,
    output logic              serial_tx,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_ovr
);
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

    typedef struct packed {
        logic [5:0]       ctrl;
        logic [DIV_W-1:0] div;
        logic [7:0]       tx_hold;
        logic             tx_full;
        logic [7:0]       rx_buf;
        logic             rx_full;
        logic             tx_ovr;
        logic             rx_ovr;
        logic [3:0]       flags;
    } regs_s;

    regs_s r_d, r_q;

    logic             wr_s, rd_s, wr_data_s, rd_data_s, wr_flag_s;
    logic             take_s, tx_ready, rx_valid;
    logic [7:0]       rx_byte;
    logic             tx_full_w, rx_full_w, tx_ovr_w, rx_ovr_w;
    logic [7:0]       rx_buf_w;
    logic [3:0]       flags_w;
    logic [DIV_W-1:0] div_w;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[BUS_W-1:DIV_W];

    assign tx_full_w = r_q.tx_full;
    assign rx_full_w = r_q.rx_full;
    assign tx_ovr_w  = r_q.tx_ovr;
    assign rx_ovr_w  = r_q.rx_ovr;
    assign rx_buf_w  = r_q.rx_buf;
    assign flags_w   = r_q.flags;
    assign div_w     = r_q.div;

    assign wr_s      = bus_sel && bus_wr;
    assign rd_s      = bus_sel && !bus_wr;
    assign wr_data_s = wr_s && (bus_addr == W_DATA);
    assign rd_data_s = rd_s && (bus_addr == W_DATA);
    assign wr_flag_s = wr_s && (bus_addr == W_FLAG);
    assign take_s    = r_q.ctrl[C_TX_EN] && tx_full_w && tx_ready;

    byte_uart_tx #(.TX_DIV_W(DIV_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (div_w),
        .load      (take_s),
        .load_byte (r_q.tx_hold),
        .ready     (tx_ready),
        .txd       (serial_tx)
    );

    byte_uart_rx #(.RX_DIV_W(DIV_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (r_q.ctrl[C_RX_EN]),
        .div     (div_w),
        .rxd     (serial_rx),
        .valid   (rx_valid),
        .rx_byte (rx_byte)
    );

    always_comb begin
        r_d = r_q;
        // software clears first, hardware events afterwards win
        if (wr_flag_s) r_d.flags = r_q.flags & ~bus_wdata[3:0];
        if (wr_s && bus_addr == W_STATE) begin
            if (bus_wdata[2]) r_d.tx_ovr = 1'b0;
            if (bus_wdata[3]) r_d.rx_ovr = 1'b0;
        end
        if (wr_s && bus_addr == W_CTRL) r_d.ctrl = bus_wdata[5:0];
        if (wr_s && bus_addr == W_DIV)
            r_d.div = (bus_wdata[DIV_W-1:0] < DIV_FLOOR) ? DIV_FLOOR : bus_wdata[DIV_W-1:0];
        if (take_s) begin
            r_d.tx_full    = 1'b0;
            r_d.flags[F_TX] = 1'b1;
        end
        if (wr_data_s) begin
            if (tx_full_w && !take_s) begin
                r_d.tx_ovr         = 1'b1;
                r_d.flags[F_TXOVR] = 1'b1;
            end else begin
                r_d.tx_hold = bus_wdata[7:0];
                r_d.tx_full = 1'b1;
            end
        end
        if (rd_data_s) r_d.rx_full = 1'b0;
        if (rx_valid) begin
            if (rx_full_w && !rd_data_s) begin
                r_d.rx_ovr         = 1'b1;
                r_d.flags[F_RXOVR] = 1'b1;
            end else begin
                r_d.rx_buf      = rx_byte;
                r_d.rx_full     = 1'b1;
                r_d.flags[F_RX] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.div <= DIV_FLOOR;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            W_DATA:  bus_rdata = BUS_W'(rx_buf_w);
            W_STATE: bus_rdata = BUS_W'({rx_ovr_w, tx_ovr_w, rx_full_w, tx_full_w});
            W_CTRL:  bus_rdata = BUS_W'(r_q.ctrl);
            W_FLAG:  bus_rdata = BUS_W'(flags_w);
            W_DIV:   bus_rdata = BUS_W'(div_w);
            default: bus_rdata = '0;
        endcase
    end

    assign irq_tx  = flags_w[F_TX] && r_q.ctrl[C_TX_IE];
    assign irq_rx  = flags_w[F_RX] && r_q.ctrl[C_RX_IE];
    assign irq_ovr = (flags_w[F_TXOVR] && r_q.ctrl[C_TXOVR_IE]) ||
                     (flags_w[F_RXOVR] && r_q.ctrl[C_RXOVR_IE]);
endmodule

// File: rtl/byte_uart_chk.sv
module byte_uart_chk
    import byte_uart_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_data,
    input logic             rd_data,
    input logic             wr_flag,
    input logic             clr_rx_bit,
    input logic             take,
    input logic             tx_ready,
    input logic             tx_full,
    input logic             tx_ovr,
    input logic             rx_valid,
    input logic             rx_full,
    input logic             rx_ovr,
    input logic [7:0]       rx_buf,
    input logic             rx_flag,
    input logic [DIV_W-1:0] div,
    input logic             serial_tx
);
    AST_TX_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && !tx_full |=> tx_full); // R4

    AST_TX_OVERRUN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && tx_full && !take |=> tx_ovr); // R4

    AST_RX_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_full && !rd_data |=> rx_ovr && $stable(rx_buf)); // R6

    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flag && clr_rx_bit && !rx_valid |=> !rx_flag); // R7

    AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        div >= DIV_W'(MIN_DIV)); // R10

    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> serial_tx); // R3
endmodule

bind byte_uart byte_uart_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data    (wr_data_s),
    .rd_data    (rd_data_s),
    .wr_flag    (wr_flag_s),
    .clr_rx_bit (bus_wdata[1]),
    .take       (take_s),
    .tx_ready   (tx_ready),
    .tx_full    (tx_full_w),
    .tx_ovr     (tx_ovr_w),
    .rx_valid   (rx_valid),
    .rx_full    (rx_full_w),
    .rx_ovr     (rx_ovr_w),
    .rx_buf     (rx_buf_w),
    .rx_flag    (flags_w[1]),
    .div        (div_w),
    .serial_tx  (serial_tx)
);

// File: tb/byte_uart_tb.sv
`timescale 1ns/1ps
module byte_uart_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        serial_rx = 1'b1;
    logic        serial_tx, irq_rx, irq_tx, irq_ovr;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    byte_uart u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .serial_rx(serial_rx), .serial_tx(serial_tx),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_ovr(irq_ovr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // tasks start and end right after a falling clock edge
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    // checks the first and last clock of each of the ten bits
    task automatic check_frame(input string req, input int div, input logic [7:0] b, input bit immediate);
        logic [9:0] fr;
        int wait_cnt;
        fr = {1'b1, b, 1'b0};
        if (!immediate) begin
            wait_cnt = 0;
            while (serial_tx !== 1'b0 && wait_cnt < 40 * div) begin
                @(negedge clk);
                wait_cnt++;
            end
        end
        for (int k = 0; k < 10 * div; k++) begin
            if ((k % div) == 0 || (k % div) == div - 1)
                check(req, {31'b0, serial_tx}, {31'b0, fr[k / div]});
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input int div, input logic [7:0] b, input logic stop);
        logic [9:0] fr;
        fr = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            serial_rx = fr[i];
            repeat (div) @(negedge clk);
        end
        serial_rx = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int divs_tx [3] = '{16, 19, 24};
        int divs_rx [3] = '{16, 21, 30};
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
        logic [7:0] rpats [4] = '{8'h3C, 8'h00, 8'hFF, 8'h96};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 reset values and register map
        check("R1 tx line", {31'b0, serial_tx}, 32'h1);
        check("R1 irqs", {29'b0, irq_rx, irq_tx, irq_ovr}, 32'h0);
        expect_reg("R1 data", 3'd0, 32'h0);
        expect_reg("R1 state", 3'd1, 32'h0);
        expect_reg("R1 ctrl", 3'd2, 32'h0);
        expect_reg("R1 flags", 3'd3, 32'h0);
        expect_reg("R1 div", 3'd4, 32'd16);
        expect_reg("R2 unmapped", 3'd6, 32'h0);
        bus_write(3'd2, 32'h2A);
        expect_reg("R2 ctrl readback", 3'd2, 32'h2A);
        bus_write(3'd2, 32'h0);

        // R10 divisor floor and width
        bus_write(3'd4, 32'd5);
        expect_reg("R10 clamp 5", 3'd4, 32'd16);
        bus_write(3'd4, 32'd0);
        expect_reg("R10 clamp 0", 3'd4, 32'd16);
        bus_write(3'd4, 32'hFFFF_FFFF);
        expect_reg("R10 full width", 3'd4, 32'h1F_FFFF);
        bus_write(3'd4, 32'd17);
        expect_reg("R10 plain", 3'd4, 32'd17);

        // R11 transmit disabled keeps the byte
        bus_write(3'd0, 32'hA5);
        for (int i = 0; i < 40; i++) begin
            if (serial_tx !== 1'b1) check("R11 line idle", {31'b0, serial_tx}, 32'h1);
            @(negedge clk);
        end
        check("R11 line idle", {31'b0, serial_tx}, 32'h1);
        expect_reg("R11 state full", 3'd1, 32'h1);

        // R4 overrun on second write
        bus_write(3'd0, 32'h3C);
        expect_reg("R4 state ovr", 3'd1, 32'h5);
        expect_reg("R4 flag ovr", 3'd3, 32'h4);
        check("R9 ovr masked", {31'b0, irq_ovr}, 32'h0);
        bus_write(3'd2, 32'h10);
        check("R9 ovr enabled", {31'b0, irq_ovr}, 32'h1);
        check("R9 tx masked", {31'b0, irq_tx}, 32'h0);
        bus_write(3'd2, 32'h15);
        check_frame("R4 held byte", 17, 8'hA5, 1'b0);
        repeat (2) @(negedge clk);
        expect_reg("R11 tx flag", 3'd3, 32'h5);
        check("R9 tx irq", {31'b0, irq_tx}, 32'h1);

        // R7 write-one-to-clear
        bus_write(3'd3, 32'h1);
        expect_reg("R7 clear tx", 3'd3, 32'h4);
        check("R9 tx irq cleared", {31'b0, irq_tx}, 32'h0);
        check("R9 ovr still", {31'b0, irq_ovr}, 32'h1);
        bus_write(3'd3, 32'h0);
        expect_reg("R7 zero no effect", 3'd3, 32'h4);
        bus_write(3'd3, 32'h4);
        expect_reg("R7 clear ovr", 3'd3, 32'h0);
        check("R9 ovr cleared", {31'b0, irq_ovr}, 32'h0);

        // R8 sticky state overrun
        expect_reg("R8 sticky", 3'd1, 32'h4);
        bus_write(3'd1, 32'h3);
        expect_reg("R8 low bits ignored", 3'd1, 32'h4);
        bus_write(3'd1, 32'h4);
        expect_reg("R8 cleared", 3'd1, 32'h0);

        // R3 transmit sweep
        foreach (divs_tx[d]) begin
            bus_write(3'd4, divs_tx[d]);
            foreach (pats[p]) begin
                bus_write(3'd0, {24'b0, pats[p]});
                check_frame("R3 frame", divs_tx[d], pats[p], 1'b0);
                repeat (2) @(negedge clk);
            end
        end
        bus_write(3'd4, 32'd16);
        bus_write(3'd0, 32'h12);
        bus_write(3'd0, 32'hED);
        check_frame("R3 back-to-back first", 16, 8'h12, 1'b1);
        check_frame("R3 back-to-back second", 16, 8'hED, 1'b1);
        repeat (2) @(negedge clk);

        // R5 receive sweep
        bus_write(3'd2, 32'h2B);
        bus_write(3'd3, 32'hF);
        foreach (divs_rx[d]) begin
            bus_write(3'd4, divs_rx[d]);
            foreach (rpats[p]) begin
                send_frame(divs_rx[d], rpats[p], 1'b1);
                expect_reg("R5 state full", 3'd1, 32'h2);
                check("R5 rx irq", {31'b0, irq_rx}, 32'h1);
                expect_reg("R5 data", 3'd0, {24'b0, rpats[p]});
                expect_reg("R5 cleared by read", 3'd1, 32'h0);
                bus_write(3'd3, 32'h2);
                check("R9 rx irq cleared", {31'b0, irq_rx}, 32'h0);
            end
        end

        // R6 receive overrun
        bus_write(3'd4, 32'd16);
        send_frame(16, 8'h11, 1'b1);
        send_frame(16, 8'h22, 1'b1);
        expect_reg("R6 state", 3'd1, 32'hA);
        expect_reg("R6 flags", 3'd3, 32'hA);
        check("R6 ovr irq", {31'b0, irq_ovr}, 32'h1);
        expect_reg("R6 kept first", 3'd0, 32'h11);
        expect_reg("R6 state after read", 3'd1, 32'h8);
        bus_write(3'd1, 32'h8);
        bus_write(3'd3, 32'hA);
        expect_reg("R8 rx ovr cleared", 3'd1, 32'h0);

        // R12 rejected frames
        send_frame(16, 8'h55, 1'b0);
        expect_reg("R12 low stop", 3'd1, 32'h0);
        check("R12 no irq", {31'b0, irq_rx}, 32'h0);
        serial_rx = 1'b0;
        repeat (3) @(negedge clk);
        serial_rx = 1'b1;
        repeat (40) @(negedge clk);
        expect_reg("R12 glitch", 3'd1, 32'h0);
        bus_write(3'd2, 32'h01);
        send_frame(16, 8'h77, 1'b1);
        expect_reg("R12 rx disabled", 3'd1, 32'h0);
        bus_write(3'd2, 32'h2B);
        send_frame(16, 8'h66, 1'b1);
        expect_reg("R12 re-enabled data", 3'd0, 32'h66);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule